// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

A cycle-accurate, synthesizable model of a synchronous SRAM in which address and control are captured on one rising clock edge and the matching data transfer takes place in the cycle that follows. Because every command owns exactly one later data cycle, reads and writes can be issued in any order on consecutive edges with no idle cycle between them. Read data is flow-through: during the data cycle the stored word is driven combinationally from the registered address, with no output register.

The array is small (256 words of two 9-bit lanes by default), written lane by lane under per-byte write enables. An internal 2-bit burst counter lets one loaded address serve up to four beats, stepped in linear or interleaved order. Three chip selects gate the start of a new operation. A clock enable freezes the whole device. An asynchronous output enable gates the read-data enable, which takes the place of a bidirectional pin.

Top module: `zbt_sram`

## Requirements
- R1: A command captured at an enabled rising edge with `adv_i`=0 and the device selected owns the following cycle as its data cycle. For a read (`wr_i`=0), `rdata_o` carries the addressed word and `rdata_oe_o`=1 during that cycle, with no extra register stage.
- R2: A read issued on the edge right after a write to the same address returns the newly written word. A write may follow a read on the next edge, with no idle cycle either way.
- R3: While `clk_en_ni`=1, every input is ignored and all state holds. A pending read keeps driving its word, and a pending write stays uncommitted until the next enabled edge.
- R4: The device is selected only when `csel_ni[0]`=0, `csel_i`=1 and `csel_ni[1]`=0. A load cycle (`adv_i`=0) with any select inactive starts nothing, but a write pending from the prior command still commits its `wdata_i`.
- R5: `rdata_oe_o` is 0 in the cycle after a deselecting load or after any write command, and is 0 out of reset.
- R6: `oe_ni`=1 forces `rdata_oe_o` to 0 in the same cycle, in any state.
- R7: `be_i` is captured with each command. Bit k=1 lets that write's data cycle store `wdata_i[9k+8:9k]` into lane k, and bit k=0 leaves lane k unchanged.
- R8: With `lin_i`=1 captured at load, beat n of a burst addresses the low two bits (start+n) mod 4, with the upper bits held.
- R9: With `lin_i`=0 captured at load, beat n addresses the low two bits start XOR n. `lin_i` is sampled only on load cycles.
- R10: An advance cycle (`adv_i`=1) continues the active burst with the command type that started it, whatever `wr_i` is. The counter wraps after four beats. An advance while idle or deselected starts nothing and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; 1 freezes the device |
| csel_ni | input | 2 | Two active-low chip selects |
| csel_i | input | 1 | Active-high chip select |
| adv_i | input | 1 | 0 loads a new address, 1 advances the burst |
| wr_i | input | 1 | Command type at load: 1 write, 0 read |
| be_i | input | LANES | Per-lane write enables, active high |
| lin_i | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data for the pending write |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Flow-through read data |
| rdata_oe_o | output | 1 | Read data valid and driven |

## Verification
The array is first filled by single writes across every address and read back in full, which separates address decoding faults from data-path faults. Alternating write/read and read/write pairs on the same address show whether the data cycle lands exactly one edge after its command. Each of the four lane-enable patterns, every start offset in both burst orders with a fifth wrapping beat, each of the seven non-selecting chip-select combinations, idle advances, frozen cycles with read and write pending, and output-enable gating are then applied. Each of these isolates one control path against a bench-side model of the requirements.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {
    ORD_INTLV = 1'b0,
    ORD_LIN   = 1'b1
  } burst_ord_e;

  function automatic logic [1:0] beat_low(input logic [1:0] start, input logic [1:0] beat,
                                          input burst_ord_e ord);
    beat_low = (ord == ORD_LIN) ? start + beat : start ^ beat;
  endfunction
endpackage

// File: rtl/zbt_lane.sv
module zbt_lane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/zbt_burst.sv
module zbt_burst
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              act_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  burst_ord_e        ord_q;
  logic              act_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
      ord_q  <= ORD_LIN;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (en_i) begin
      if (load_i) begin
        act_q <= start_i;
        if (start_i) begin
          base_q <= addr_i;
          beat_q <= '0;
          ord_q  <= lin_i ? ORD_LIN : ORD_INTLV;
          wr_q   <= wr_i;
        end
      end else if (act_q) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign act_o  = act_q;
  assign wr_o   = wr_q;
  assign addr_o = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_q, ord_q)};

  // R10: advancing never leaves the 4-word block
  a_r10_block_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && act_q) |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));
  // R8: linear order steps the low bits by one
  a_r8_lin_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && act_q && ord_q == ORD_LIN) |=> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);
  // R9: interleaved offset from start counts up by one
  a_r9_intlv_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && act_q && ord_q == ORD_INTLV)
    |=> (addr_o[1:0] ^ base_q[1:0]) == $past(addr_o[1:0] ^ base_q[1:0]) + 2'd1);
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_ni,
  input  logic [1:0]              csel_ni,
  input  logic                    csel_i,
  input  logic                    adv_i,
  input  logic                    wr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic                    lin_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_ni,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  logic              en, load, sel_ok;
  logic              pend_v_q, pend_wr_q;
  logic [LANES-1:0]  pend_be_q;
  logic              burst_act, burst_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic              commit;

  assign en     = !clk_en_ni;
  assign load   = !adv_i;
  assign sel_ok = !csel_ni[0] && !csel_ni[1] && csel_i;

  zbt_burst #(.ADDR_W(ADDR_W)) i_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .load_i  (load),
    .start_i (sel_ok),
    .wr_i    (wr_i),
    .lin_i   (lin_i),
    .addr_i  (addr_i),
    .act_o   (burst_act),
    .wr_o    (burst_wr),
    .addr_o  (cur_addr)
  );

  // data-cycle state of the command captured at the last enabled edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q  <= 1'b0;
      pend_wr_q <= 1'b0;
      pend_be_q <= '0;
    end else if (en) begin
      pend_v_q  <= load ? sel_ok : burst_act;
      pend_wr_q <= load ? wr_i : burst_wr;
      pend_be_q <= be_i;
    end
  end

  assign commit = en && pend_v_q && pend_wr_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    zbt_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_lane (
      .clk_i   (clk_i),
      .we_i    (commit && pend_be_q[k]),
      .addr_i  (cur_addr),
      .wdata_i (wdata_i[k*LANE_W +: LANE_W]),
      .rdata_o (rdata_o[k*LANE_W +: LANE_W])
    );
  end

  assign rdata_oe_o = pend_v_q && !pend_wr_q && !oe_ni;

  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> $stable(pend_v_q) && $stable(pend_wr_q) && $stable(cur_addr));
  a_r5_quiet_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && load && sel_ok && wr_i) |=> !rdata_oe_o);
  a_r5_quiet_after_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && load && !sel_ok) |=> !rdata_oe_o);
  a_r6_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rdata_oe_o);
  a_r1_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && load && sel_ok && !wr_i) |=> (rdata_oe_o || oe_ni));
  a_r10_idle_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !load && !burst_act) |=> !rdata_oe_o);
endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
  localparam int AW = 8;
  localparam int DW = 18;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni, clk_en_ni, csel_i, adv_i, wr_i, lin_i, oe_ni, rdata_oe_o;
  logic [1:0]    csel_ni, be_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, rdata_o;

  zbt_sram i_zbt_sram (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni), .csel_ni(csel_ni), .csel_i(csel_i),
    .adv_i(adv_i), .wr_i(wr_i), .be_i(be_i), .lin_i(lin_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .oe_ni(oe_ni), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  int total = 0, bad = 0;
  string tag = "R1";
  logic [DW-1:0] mm [256];
  logic          mv = 0, mwr = 0, mact = 0, mbwr = 0, mlin = 1;
  logic [AW-1:0] mbase = '0;
  logic [1:0]    mbeat = '0, mbe = '0;
  logic [31:0]   seed = 32'h1234_5678;

  function automatic logic [AW-1:0] maddr();
    return {mbase[AW-1:2], mlin ? mbase[1:0] + mbeat : mbase[1:0] ^ mbeat};
  endfunction

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  // m: bit0 csel_ni[0] asserted, bit1 csel_i asserted, bit2 csel_ni[1] asserted
  task automatic step(input bit en, input bit adv, input bit wr, input bit [2:0] m,
                      input bit [1:0] be, input bit [AW-1:0] a, input bit lin, input bit oen);
    logic          exp_oe;
    logic [DW-1:0] wd;
    @(negedge clk);
    exp_oe = mv && !mwr && !oe_ni;
    chk(tag, {17'd0, rdata_oe_o}, {17'd0, exp_oe});
    if (exp_oe) chk(tag, rdata_o, mm[maddr()]);
    seed = seed * 32'd1103515245 + 32'd12345;
    wd = seed[25:8];
    clk_en_ni = !en; adv_i = adv; wr_i = wr;
    csel_ni[0] = !m[0]; csel_i = m[1]; csel_ni[1] = !m[2];
    be_i = be; addr_i = a; lin_i = lin; oe_ni = oen; wdata_i = wd;
    @(posedge clk);
    if (en) begin
      if (mv && mwr) begin
        if (mbe[0]) mm[maddr()][8:0]  = wd[8:0];
        if (mbe[1]) mm[maddr()][17:9] = wd[17:9];
      end
      if (!adv) begin
        if (&m) begin
          mv = 1; mwr = wr; mact = 1; mbwr = wr; mbase = a; mbeat = 0; mlin = lin;
        end else begin
          mv = 0; mact = 0;
        end
      end else if (mact) begin
        mbeat = mbeat + 2'd1; mv = 1; mwr = mbwr;
      end else begin
        mv = 0;
      end
      mbe = be;
    end
  endtask

  task automatic wr1(input bit [AW-1:0] a, input bit [1:0] be); step(1, 0, 1, 3'b111, be, a, 1, 0); endtask
  task automatic rd1(input bit [AW-1:0] a); step(1, 0, 0, 3'b111, 2'b11, a, 1, 0); endtask
  task automatic nop(); step(1, 0, 0, 3'b000, 2'b11, '0, 1, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = '0;
    rst_ni = 0; clk_en_ni = 0; csel_ni = 2'b11; csel_i = 0; adv_i = 0; wr_i = 0;
    be_i = 2'b11; lin_i = 1; addr_i = '0; wdata_i = '0; oe_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 reset", {17'd0, rdata_oe_o}, 18'd0);
    rst_ni = 1;

    tag = "R1";
    for (int a = 0; a < 256; a++) wr1(a[AW-1:0], 2'b11);
    for (int a = 0; a < 256; a++) rd1(a[AW-1:0]);
    nop();

    tag = "R2";
    for (int a = 0; a < 64; a++) begin
      wr1(a[AW-1:0], 2'b11); rd1(a[AW-1:0]);
      rd1(8'(a + 64)); wr1(8'(a + 64), 2'b11); rd1(8'(a + 64));
    end
    nop();

    tag = "R7";
    for (int b = 0; b < 4; b++) begin
      for (int a = 128; a < 136; a++) begin wr1(a[AW-1:0], b[1:0]); rd1(a[AW-1:0]); end
    end
    nop();

    for (int l = 0; l < 2; l++) begin
      tag = (l == 1) ? "R8" : "R9";
      for (int s = 0; s < 4; s++) begin
        step(1, 0, 1, 3'b111, 2'b11, 8'(160 + 4 * s + s), l[0], 0);
        for (int k = 0; k < 3; k++) step(1, 1, 0, 3'b111, 2'b11, '0, 0, 0);
        nop();
        step(1, 0, 0, 3'b111, 2'b11, 8'(160 + 4 * s + s), l[0], 0);
        for (int k = 0; k < 4; k++) step(1, 1, 1, 3'b111, 2'b11, '0, !l[0], 0);
        nop();
        step(1, 0, 0, 3'b111, 2'b11, 8'(160 + 4 * s), !l[0], 0);
        for (int k = 0; k < 3; k++) step(1, 1, 0, 3'b111, 2'b11, '0, 0, 0);
        nop();
      end
    end

    tag = "R3";
    rd1(8'd5);
    for (int k = 0; k < 4; k++) step(0, k[0], 1, k[2:0], 2'b00, 8'(k * 9), k[1], 0);
    nop();
    wr1(8'd6, 2'b11);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 3'b111, 2'b00, 8'd7, 1, 0);
    nop();
    rd1(8'd6); rd1(8'd7);
    nop();

    tag = "R4";
    for (int m = 0; m < 7; m++) step(1, 0, 0, m[2:0], 2'b11, 8'd9, 1, 0);
    nop();
    wr1(8'd10, 2'b11);
    step(1, 0, 0, 3'b011, 2'b11, 8'd10, 1, 0);
    nop();
    rd1(8'd10);
    nop();

    tag = "R5";
    rd1(8'd11); wr1(8'd11, 2'b11); rd1(8'd11);
    step(1, 0, 0, 3'b110, 2'b11, 8'd11, 1, 0);
    nop();

    tag = "R6";
    step(1, 0, 0, 3'b111, 2'b11, 8'd12, 1, 1);
    step(1, 0, 0, 3'b111, 2'b11, 8'd13, 1, 0);
    step(1, 0, 0, 3'b111, 2'b11, 8'd14, 1, 1);
    nop();

    tag = "R10";
    nop();
    step(1, 1, 1, 3'b111, 2'b11, 8'd20, 1, 0);
    step(1, 1, 1, 3'b111, 2'b11, 8'd21, 1, 0);
    nop();
    rd1(8'd20); rd1(8'd21); rd1(8'd0);
    nop(); nop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule